// File: doc/BRIEF.md
# PCI Slot Interrupt Router with Legacy-Routing Detection

This block takes the four level interrupt pins (A to D) of every PCI slot and merges them onto four host interrupt lines. Two board wirings are supported, and a variant input picks between them. Each wiring adds its own fixed rotation to the usual slot-plus-pin swizzle. Host output 0 to 3 stands for the first four consecutive board interrupt numbers of the selected wiring.

Some older guest software programs interrupt-line values that only make sense under an obsolete, unswizzled routing. To support that software, the block snoops configuration-space writes (address, data, strobe). It forwards every write unchanged in the same cycle. It classifies the first write to a slot's interrupt-line byte that tells the two kinds of software apart. The result is held in a sticky three-state mode: undecided, legacy or fixed. In legacy mode every pin goes to the output with its own pin number, and the slot has no effect. Detection is active only for the base wiring.

Top module: `pci_irq_router`

## Requirements
- R1: After reset, mode_o holds the INIT_MODE parameter (default 0). The encodings are 0 = undecided, 1 = legacy, 2 = fixed.
- R2: Once mode_o is 1 or 2, it keeps that value until the next reset, whatever writes follow.
- R3: A write is classified only when all of these hold: cfg_we_i is 1, cfg_addr_i[7:0] equals the interrupt-line offset 0x3C, variant_i is 0 and the mode is 0. Any other write leaves the mode unchanged.
- R4: The slot used by the classifier is cfg_addr_i[15:8] shifted right by 3, taken modulo 4, which is cfg_addr_i[12:11].
- R5: A classified write of value 27 leaves the mode at 0 when the slot modulo 4 is 2. For any other slot it sets mode 1.
- R6: A classified write of value 27+s or 91+s, where s is the slot modulo 4, sets mode 1. Any other value sets mode 2. All 32 data bits are compared.
- R7: In modes 0 and 2 with variant_i = 0, pin p (A=0 to D=3) of slot n drives irq_o[(n+p+2) mod 4]. Slot n's pins are slot_irq_i[4n+3:4n].
- R8: In modes 0 and 2 with variant_i = 1, pin p of slot n drives irq_o[(n+p+3) mod 4].
- R9: In mode 1, pin p of every slot drives irq_o[p], for either variant.
- R10: Each irq_o bit is the OR of the pin levels routed to it. It follows the inputs combinationally within the same cycle. A mode change takes effect in the cycle after the write edge.
- R11: cfg_we_o, cfg_addr_o and cfg_wdata_o equal the corresponding inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| variant_i | input | 1 | Board wiring select: 0 base, 1 alternate |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W (24) | Configuration address; [15:8] device/function, [7:0] register |
| cfg_wdata_i | input | DATA_W (32) | Configuration write data |
| cfg_we_o | output | 1 | Forwarded write strobe |
| cfg_addr_o | output | ADDR_W (24) | Forwarded address |
| cfg_wdata_o | output | DATA_W (32) | Forwarded data |
| slot_irq_i | input | NUM_SLOTS*4 (128) | Pin levels, four per slot, pin A lowest |
| irq_o | output | 4 | Host interrupt levels |
| mode_o | output | 2 | Current routing mode |

## Verification
The bench targets the following corner cases:
- Value 27 on slot 2, where the legacy and correct routings agree. A design that decided here would lock into a mode too early.
- Value 27 on slot 0, which equals both the plain constant and slot+27.
- The 91+s form, and a value whose low byte matches but whose upper bits are set. A design that compares only the low byte would wrongly pick legacy.
- Writes at the wrong offset, with the strobe low, or under the alternate wiring. Any of these that moved the mode would be a bug.
- Later contradicting writes after a decision. A design that is not sticky would flip the routing.
- Single-pin walks over every slot in both wirings and in legacy mode. These expose a wrong rotation constant or a slot-index error.

// File: rtl/pci_irq_router_pkg.sv
package pci_irq_router_pkg;
  typedef enum logic [1:0] {
    MODE_UNDECIDED = 2'd0,
    MODE_LEGACY    = 2'd1,
    MODE_FIXED     = 2'd2
  } route_mode_e;
endpackage

// File: rtl/iline_write_classifier.sv
module iline_write_classifier
  import pci_irq_router_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int BASE_IRQ     = 27,
  parameter int LEGACY_SHIFT = 64,
  parameter int AMBIG_SLOT   = 2
) (
  input  logic [1:0]        slot_mod_i,
  input  logic [DATA_W-1:0] wdata_i,
  output route_mode_e       verdict_o
);
  localparam logic [DATA_W-1:0] BASE_V  = DATA_W'(BASE_IRQ);
  localparam logic [DATA_W-1:0] SHIFT_V = DATA_W'(LEGACY_SHIFT);

  logic [DATA_W-1:0] swz_v;
  assign swz_v = BASE_V + DATA_W'(slot_mod_i);

  always_comb begin
    if (wdata_i == BASE_V)
      verdict_o = (slot_mod_i == 2'(AMBIG_SLOT)) ? MODE_UNDECIDED : MODE_LEGACY;
    else if (wdata_i == swz_v || wdata_i == swz_v + SHIFT_V)
      verdict_o = MODE_LEGACY;
    else
      verdict_o = MODE_FIXED;
  end
endmodule

// File: rtl/route_mode_tracker.sv
module route_mode_tracker
  import pci_irq_router_pkg::*;
#(
  parameter int          DATA_W       = 32,
  parameter logic [7:0]  ILINE_OFFSET = 8'h3C,
  parameter int          BASE_IRQ     = 27,
  parameter int          LEGACY_SHIFT = 64,
  parameter logic [1:0]  INIT_MODE    = 2'd0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              variant_i,
  input  logic              cfg_we_i,
  input  logic [7:0]        reg_off_i,
  input  logic [1:0]        slot_mod_i,
  input  logic [DATA_W-1:0] wdata_i,
  output route_mode_e       mode_o
);
  route_mode_e mode_q, verdict;
  logic        snoop_hit;

  iline_write_classifier #(
    .DATA_W(DATA_W), .BASE_IRQ(BASE_IRQ), .LEGACY_SHIFT(LEGACY_SHIFT), .AMBIG_SLOT(2)
  ) u_cls (
    .slot_mod_i(slot_mod_i), .wdata_i(wdata_i), .verdict_o(verdict)
  );

  assign snoop_hit = cfg_we_i && !variant_i && (reg_off_i == ILINE_OFFSET)
                     && (mode_q == MODE_UNDECIDED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= route_mode_e'(INIT_MODE);
    else if (snoop_hit) mode_q <= verdict;
  end

  assign mode_o = mode_q;

  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_UNDECIDED) |=> (mode_q == $past(mode_q)));

  assert_no_snoop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i || variant_i || reg_off_i != ILINE_OFFSET) |=> $stable(mode_q));

  assert_ambig_slot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !variant_i && reg_off_i == ILINE_OFFSET && mode_q == MODE_UNDECIDED
     && wdata_i == DATA_W'(BASE_IRQ) && slot_mod_i == 2'd2) |=> (mode_q == MODE_UNDECIDED));

  assert_shifted_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !variant_i && reg_off_i == ILINE_OFFSET && mode_q == MODE_UNDECIDED
     && wdata_i == DATA_W'(BASE_IRQ + LEGACY_SHIFT) + DATA_W'(slot_mod_i))
    |=> (mode_q == MODE_LEGACY));
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix #(
  parameter int NUM_SLOTS   = 32,
  parameter int NUM_PINS    = 4,
  parameter int BASE_ROTATE = 2,
  parameter int ALT_ROTATE  = 3
) (
  input  logic [NUM_SLOTS*NUM_PINS-1:0] pins_i,
  input  logic                          variant_i,
  input  logic                          legacy_i,
  output logic [NUM_PINS-1:0]           irq_o
);
  localparam int SRC_N = NUM_SLOTS * NUM_PINS;
  localparam int SEL_W = $clog2(NUM_PINS);

  logic [SEL_W-1:0]    rot;
  logic [NUM_PINS-1:0] contrib [SRC_N];

  assign rot = variant_i ? SEL_W'(ALT_ROTATE) : SEL_W'(BASE_ROTATE);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int K = s * NUM_PINS + p;
      logic [SEL_W-1:0] dest;
      // power-of-two pin count: truncation is the modulo
      assign dest = legacy_i ? SEL_W'(p) : SEL_W'(s + p) + rot;
      assign contrib[K] = pins_i[K] ? (NUM_PINS'(1) << dest) : '0;
    end
  end

  always_comb begin
    irq_o = '0;
    for (int k = 0; k < SRC_N; k++) irq_o |= contrib[k];
  end
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pci_irq_router_pkg::*;
#(
  parameter int          NUM_SLOTS    = 32,
  parameter int          ADDR_W       = 24,
  parameter int          DATA_W       = 32,
  parameter logic [7:0]  ILINE_OFFSET = 8'h3C,
  parameter int          BASE_IRQ     = 27,
  parameter int          LEGACY_SHIFT = 64,
  parameter logic [1:0]  INIT_MODE    = 2'd0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      variant_i,
  input  logic                      cfg_we_i,
  input  logic [ADDR_W-1:0]         cfg_addr_i,
  input  logic [DATA_W-1:0]         cfg_wdata_i,
  output logic                      cfg_we_o,
  output logic [ADDR_W-1:0]         cfg_addr_o,
  output logic [DATA_W-1:0]         cfg_wdata_o,
  input  logic [NUM_SLOTS*4-1:0]    slot_irq_i,
  output logic [3:0]                irq_o,
  output logic [1:0]                mode_o
);
  localparam int DEVFN_LSB = 8;
  localparam int SLOT_LSB  = DEVFN_LSB + 3;

  route_mode_e mode;

  assign cfg_we_o    = cfg_we_i;
  assign cfg_addr_o  = cfg_addr_i;
  assign cfg_wdata_o = cfg_wdata_i;

  route_mode_tracker #(
    .DATA_W(DATA_W), .ILINE_OFFSET(ILINE_OFFSET), .BASE_IRQ(BASE_IRQ),
    .LEGACY_SHIFT(LEGACY_SHIFT), .INIT_MODE(INIT_MODE)
  ) u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .variant_i(variant_i), .cfg_we_i(cfg_we_i),
    .reg_off_i(cfg_addr_i[7:0]), .slot_mod_i(cfg_addr_i[SLOT_LSB+1:SLOT_LSB]),
    .wdata_i(cfg_wdata_i), .mode_o(mode)
  );

  irq_route_matrix #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_PINS(4), .BASE_ROTATE(2), .ALT_ROTATE(3)
  ) u_route (
    .pins_i(slot_irq_i), .variant_i(variant_i),
    .legacy_i(mode == MODE_LEGACY), .irq_o(irq_o)
  );

  assign mode_o = mode;

  assert_idle_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_irq_i == '0) |-> (irq_o == '0));

  assert_any_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|slot_irq_i) |-> (|irq_o));
endmodule

// File: tb/sim_pci_irq_router.sv
`timescale 1ns/1ps
module sim_pci_irq_router;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         variant = 1'b0;
  logic         we = 1'b0;
  logic [23:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic [127:0] pins = '0;
  logic         we_f;
  logic [23:0]  addr_f;
  logic [31:0]  wdata_f;
  logic [3:0]   irq;
  logic [1:0]   mode;

  int checks = 0;
  int errors = 0;
  int ref_mode = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pci_irq_router u0 (
    .clk_i(clk), .rst_ni(rst_n), .variant_i(variant), .cfg_we_i(we),
    .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_we_o(we_f), .cfg_addr_o(addr_f),
    .cfg_wdata_o(wdata_f), .slot_irq_i(pins), .irq_o(irq), .mode_o(mode)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_irq(input int m, input bit v, input logic [127:0] p);
    logic [3:0] r = '0;
    for (int n = 0; n < 32; n++)
      for (int q = 0; q < 4; q++)
        if (p[4*n+q]) r[(m == 1) ? q : (n + q + (v ? 3 : 2)) % 4] = 1'b1;
    return r;
  endfunction

  // one cycle: drive, compare combinational outputs, advance model at the edge
  task automatic step(input string tag, input bit w, input logic [23:0] a,
                      input logic [31:0] d, input bit v, input logic [127:0] p);
    int s;
    @(negedge clk);
    we = w; addr = a; wdata = d; variant = v; pins = p;
    #1;
    chk({tag, " irq"}, 64'(irq), 64'(exp_irq(ref_mode, v, p)));
    chk({tag, " mode"}, 64'(mode), 64'(ref_mode));
    chk("R11 forward", {31'(0), we_f, addr_f, wdata_f}, {31'(0), w, a, d});
    if (ref_mode == 0 && w && !v && a[7:0] == 8'h3C) begin
      s = (int'(a[15:8]) >> 3) % 4;
      if (d == 32'd27)                                  ref_mode = (s == 2) ? 0 : 1;
      else if (d == 32'(27 + s) || d == 32'(91 + s))    ref_mode = 1;
      else                                              ref_mode = 2;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0; pins = '0;
    #1;
    chk("R1 reset mode", 64'(mode), 64'd0);
    chk("R1 reset irq", 64'(irq), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    ref_mode = 0;
  endtask

  function automatic logic [23:0] il(input int slot, input int off);
    return 24'((slot << 11) | off);
  endfunction

  function automatic logic [127:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    do_reset();
    for (int k = 0; k < 128; k++) step("R7", 0, 0, 0, 0, 128'(1) << k);
    for (int k = 0; k < 128; k++) step("R8", 0, 0, 0, 1, 128'(1) << k);
    for (int k = 0; k < 40; k++)  step("R10", 0, 0, 0, k[0], rnd());
    // writes that must not classify
    step("R3", 1, il(1, 8'h3D), 32'd200, 0, rnd());
    step("R3", 0, il(1, 8'h3C), 32'd200, 0, rnd());
    step("R3", 1, il(1, 8'h3C), 32'd200, 1, rnd());
    step("R3", 1, il(3, 8'h3C) | 24'h10000, 32'd94, 1, rnd());
    step("R5", 1, il(2, 8'h3C), 32'd27, 0, rnd());
    step("R5", 1, il(6, 8'h3C), 32'd27, 0, rnd());
    step("R5", 0, 0, 0, 0, rnd());
    chk("R5 slot2 undecided", 64'(mode), 64'd0);
    // slot 5 -> mod 1, value 28 => legacy
    step("R4", 1, il(5, 8'h3C) | 24'h300, 32'd28, 0, rnd());
    for (int k = 0; k < 128; k++) step("R9", 0, 0, 0, k[0], 128'(1) << k);
    step("R2", 1, il(0, 8'h3C), 32'd200, 0, rnd());
    step("R2", 1, il(1, 8'h3C), 32'd29, 0, rnd());
    for (int k = 0; k < 10; k++) step("R9", 0, 0, 0, k[0], rnd());
    chk("R9 legacy held", 64'(mode), 64'd1);

    do_reset();
    step("R6", 1, il(3, 8'h3C), 32'd200, 0, rnd());
    step("R2", 1, il(3, 8'h3C), 32'd30, 0, rnd());
    for (int k = 0; k < 20; k++) step("R7", 0, 0, 0, k[0], rnd());
    chk("R6 fixed", 64'(mode), 64'd2);

    do_reset();
    step("R6", 1, il(7, 8'h3C), 32'd94, 0, rnd());
    step("R6", 0, 0, 0, 0, rnd());
    chk("R6 shifted legacy", 64'(mode), 64'd1);

    do_reset();
    step("R6", 1, il(0, 8'h3C), 32'h0000_011B, 0, rnd());
    step("R6", 0, 0, 0, 0, rnd());
    chk("R6 upper bits", 64'(mode), 64'd2);

    do_reset();
    step("R5", 1, il(4, 8'h3C), 32'd27, 0, rnd());
    step("R5", 0, 0, 0, 0, rnd());
    chk("R5 slot0 legacy", 64'(mode), 64'd1);

    do_reset();
    step("R4", 1, il(10, 8'h3C) | 24'h700, 32'd29, 0, rnd());
    step("R4", 0, 0, 0, 0, rnd());
    chk("R4 slot mod", 64'(mode), 64'd1);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule